// File: doc/BRIEF.md
# Modem Status Generator with Loopback and Change Capture

This block builds the 8-bit modem status byte of a 16550-compatible serial port from the port's modem control value. The upper nibble carries four status lines: clear-to-send, data-set-ready, ring indicator and carrier detect. The lower nibble carries sticky change flags for those lines. When the loopback control bit is set, the control outputs are wired back onto the status lines. When it is clear, the block presents a fixed idle pattern: carrier and data-set-ready high, the other two lines low.

The status lines change only on a control write. On that write, each line that moves sets its change flag. The ring indicator flag is the exception: it is set only when ring goes from 1 to 0. A status read presents the current byte in the read cycle and clears the change flags at the following edge. A change captured in that same cycle survives the clear. The `delta_any` output tells the interrupt logic that at least one change flag is pending.

Top module: `modem_status_unit`

## Requirements
- R1: After reset, `sts_byte` is 0xA0 and `delta_any` is 0.
- R2: A control write with bit 4 (loopback) set drives the status lines at the next edge as follows. Status bit 4 takes control bit 1. Status bit 5 takes control bit 0. Status bit 6 takes control bit 2. Status bit 7 takes control bit 3.
- R3: A control write with bit 4 clear sets status bits 7..4 to 1010 at the next edge.
- R4: On a control write, status bit 0 (CTS change), bit 1 (DSR change) and bit 3 (DCD change) are set whenever status bit 4, 5 or 7 respectively takes a new value.
- R5: Status bit 2 is set on a control write only when status bit 6 goes from 1 to 0. A rise of bit 6 leaves bit 2 unchanged.
- R6: A control write never clears a change flag that is already set.
- R7: In a cycle with `sts_rd` high, `sts_byte` shows the pre-read value. At the next edge, bits 3..0 are cleared, unless R8 applies.
- R8: When a control write and a status read fall in the same cycle, the change flags raised by that write are set after the edge.
- R9: `delta_any` is 1 exactly when any of status bits 3..0 is 1.
- R10: Without a control write, status bits 7..4 hold their value and no change flag becomes set. A write that leaves every line unchanged sets no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control-register write strobe, one cycle per write |
| ctl_val | input | CTL_W (5) | Masked control value. Bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback |
| sts_rd | input | 1 | Status-register read strobe |
| sts_byte | output | 8 | Status byte: lines in bits 7..4, change flags in bits 3..0 |
| delta_any | output | 1 | High while any change flag is set |

## Verification
The bench chases the ring trailing-edge rule by raising ring and then dropping it. A design that flags any toggle would set bit 2 on the rise. The bench also enters and leaves loopback, where carrier and data-set-ready fall and rise together. A design that compared against the control value instead of the previous line state would miss these flags. Reads coincide with flag-raising writes, so a design that lets the clear win would lose the new flag. Long random stretches mix back-to-back writes with no-change writes, and the bench checks whether any flag appears, vanishes without a read, or appears without a line change.

// File: rtl/msr_pkg.sv
package msr_pkg;
   // Index of each status line inside the 4-bit line vector.
   // The same index selects the matching change flag.
   localparam int LN_CTS = 0;
   localparam int LN_DSR = 1;
   localparam int LN_RI  = 2;
   localparam int LN_DCD = 3;
   localparam int N_LINES = 4;

   // Control bit positions
   localparam int CB_DTR  = 0;
   localparam int CB_RTS  = 1;
   localparam int CB_OUT1 = 2;
   localparam int CB_OUT2 = 3;
   localparam int CB_LOOP = 4;
   localparam int CTL_MIN_W = 5;

   typedef logic [N_LINES-1:0] lines_t;

   // Line state outside loopback: carrier and data-set-ready high
   localparam lines_t LINES_IDLE = lines_t'(4'b1010);
endpackage

// File: rtl/msr_line_map.sv
module msr_line_map
   import msr_pkg::*;
#(
   parameter int CTL_W        = 5,
   parameter bit HAS_LOOPBACK = 1'b1
) (
   input  logic [CTL_W-1:0] ctl,
   output lines_t           lines
);
   generate
      if (CTL_W < CTL_MIN_W) begin : g_bad_w
         $error("msr_line_map: CTL_W must be at least 5");
      end

      if (HAS_LOOPBACK) begin : g_loop
         lines_t wired;
         always_comb begin
            wired         = '0;
            wired[LN_CTS] = ctl[CB_RTS];
            wired[LN_DSR] = ctl[CB_DTR];
            wired[LN_RI]  = ctl[CB_OUT1];
            wired[LN_DCD] = ctl[CB_OUT2];
         end
         assign lines = ctl[CB_LOOP] ? wired : LINES_IDLE;
      end else begin : g_fixed
         logic unused_ctl;
         assign unused_ctl = ^ctl;
         assign lines      = LINES_IDLE;
      end
   endgenerate
endmodule

// File: rtl/msr_delta_track.sv
module msr_delta_track
   import msr_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   upd,
   input  logic   clr,
   input  lines_t nxt_lines,
   output lines_t cur_lines,
   output lines_t flags
);
   lines_t ev;

   // Per-line event rule: ring reports only its trailing edge
   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_ev
         if (i == LN_RI) begin : g_fall
            assign ev[i] = cur_lines[i] & ~nxt_lines[i];
         end else begin : g_any
            assign ev[i] = cur_lines[i] ^ nxt_lines[i];
         end
      end
   endgenerate

   lines_t flags_nxt;
   always_comb begin
      flags_nxt = clr ? '0 : flags;
      if (upd) flags_nxt = flags_nxt | ev;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_lines <= LINES_IDLE;
         flags     <= '0;
      end else begin
         if (upd) cur_lines <= nxt_lines;
         flags <= flags_nxt;
      end
   end
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
   import msr_pkg::*;
#(
   parameter int CTL_W        = 5,
   parameter bit HAS_LOOPBACK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_val,
   input  logic             sts_rd,
   output logic [7:0]       sts_byte,
   output logic             delta_any
);
   localparam int STS_W = 2 * N_LINES;

   generate
      if (STS_W != 8) begin : g_bad_sts
         $error("modem_status_unit: status byte must be 8 bits");
      end
   endgenerate

   lines_t mapped;
   lines_t lines_q;
   lines_t flags_q;

   msr_line_map #(
      .CTL_W        (CTL_W),
      .HAS_LOOPBACK (HAS_LOOPBACK)
   ) u_map (
      .ctl   (ctl_val),
      .lines (mapped)
   );

   msr_delta_track u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd       (ctl_wr),
      .clr       (sts_rd),
      .nxt_lines (mapped),
      .cur_lines (lines_q),
      .flags     (flags_q)
   );

   assign sts_byte  = {lines_q, flags_q};
   assign delta_any = |flags_q;
endmodule

// File: rtl/msr_checker.sv
module msr_checker #(
   parameter int CTL_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_wr,
   input logic [CTL_W-1:0] ctl_val,
   input logic             sts_rd,
   input logic [7:0]       sts_byte,
   input logic             delta_any
);
   // R2
   loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_val[4]) |=>
         sts_byte[7:4] == {$past(ctl_val[3]), $past(ctl_val[2]),
                           $past(ctl_val[0]), $past(ctl_val[1])});
   // R3
   idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_val[4]) |=> sts_byte[7:4] == 4'b1010);
   // R7
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_rd && !ctl_wr) |=> sts_byte[3:0] == 4'b0000);
   // R10
   hold_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(sts_byte[7:4]));
   // R10
   no_new_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> (sts_byte[3:0] & ~$past(sts_byte[3:0])) == 4'b0000);
   // R6
   sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_rd |=> (sts_byte[3:0] & $past(sts_byte[3:0])) == $past(sts_byte[3:0]));
   // R5
   ring_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_byte[2]) |-> $fell(sts_byte[6]));
   // R9
   any_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      delta_any == (sts_byte[3:0] != 4'b0000));
endmodule

bind modem_status_unit msr_checker #(.CTL_W(CTL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_wr    (ctl_wr),
   .ctl_val   (ctl_val),
   .sts_rd    (sts_rd),
   .sts_byte  (sts_byte),
   .delta_any (delta_any)
);

// File: tb/sim_modem_status_unit.sv
module sim_modem_status_unit;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [4:0] ctl_val = '0;
   logic       sts_rd = 1'b0;
   logic [7:0] sts_byte;
   logic       delta_any;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   // reference state: line bits {dcd,ri,dsr,cts} and change flags
   logic [3:0] m_lines;
   logic [3:0] m_flags;

   always #(CLK_PERIOD/2) clk = ~clk;

   modem_status_unit u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .ctl_val   (ctl_val),
      .sts_rd    (sts_rd),
      .sts_byte  (sts_byte),
      .delta_any (delta_any)
   );

   function automatic logic [3:0] expect_lines(input logic [4:0] c);
      logic [3:0] r;
      if (c[4]) begin
         r[3] = c[3];
         r[2] = c[2];
         r[1] = c[0];
         r[0] = c[1];
      end else begin
         r = 4'b1010;
      end
      return r;
   endfunction

   task automatic compare(input string tag);
      n_vec++;
      if (sts_byte !== {m_lines, m_flags}) begin
         n_bad++;
         $display("FAIL %s: status actual %h expected %h", tag, sts_byte, {m_lines, m_flags});
      end
      n_vec++;
      if (delta_any !== (m_flags != 0)) begin
         n_bad++;
         $display("FAIL R9 (%s): delta_any actual %b expected %b", tag, delta_any, m_flags != 0);
      end
   endtask

   // Drive one cycle's inputs (at a falling edge), check the present state,
   // then advance the reference model across the rising edge.
   task automatic step(input logic wr, input logic [4:0] val, input logic rd, input string tag);
      logic [3:0] nl;
      ctl_wr  = wr;
      ctl_val = val;
      sts_rd  = rd;
      compare(tag);
      @(posedge clk);
      if (rd) m_flags = 4'b0000;
      if (wr) begin
         nl = expect_lines(val);
         if (nl[0] != m_lines[0]) m_flags[0] = 1'b1;
         if (nl[1] != m_lines[1]) m_flags[1] = 1'b1;
         if (m_lines[2] && !nl[2]) m_flags[2] = 1'b1;
         if (nl[3] != m_lines[3]) m_flags[3] = 1'b1;
         m_lines = nl;
      end
      @(negedge clk);
   endtask

   initial begin
      m_lines = 4'b1010;
      m_flags = 4'b0000;
      repeat (3) @(negedge clk);
      compare("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      step(1'b0, 5'h00, 1'b0, "R1 after reset");
      step(1'b1, 5'h00, 1'b0, "R3 R10 idle write");
      step(1'b0, 5'h00, 1'b0, "R10 no-change write flags");
      step(1'b1, 5'h10, 1'b0, "R4 enter loopback");
      step(1'b0, 5'h00, 1'b1, "R7 read shows flags");
      step(1'b0, 5'h00, 1'b0, "R7 flags cleared");
      step(1'b1, 5'h14, 1'b0, "R5 ring rises");
      step(1'b0, 5'h00, 1'b0, "R5 no flag on rise");
      step(1'b1, 5'h10, 1'b0, "R5 ring falls");
      step(1'b1, 5'h13, 1'b0, "R2 rts dtr wired");
      step(1'b1, 5'h1F, 1'b0, "R6 sticky flags");
      step(1'b0, 5'h00, 1'b1, "R7 read");
      step(1'b1, 5'h17, 1'b1, "R8 write with read");
      step(1'b0, 5'h00, 1'b0, "R8 new flag kept");
      step(1'b1, 5'h00, 1'b1, "R8 leave loopback with read");
      step(1'b0, 5'h00, 1'b0, "R3 idle after loopback");
      for (int k = 0; k < 400; k++) begin
         logic [31:0] r;
         r = $urandom;
         step(r[0] | r[1], r[8:4], r[2] & r[3], "R2 R4 R5 R6 R8 R10 random");
      end
      step(1'b0, 5'h00, 1'b0, "R10 final");
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not end, actual hung expected finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule